// File: doc/BRIEF.md
# Paged Priority Interrupt Controller

This block arbitrates up to 128 maskable interrupt request lines for one CPU. Every line owns a 3-bit priority level. Level 0 switches the line off, and levels 1 to 7 rank it, with 7 the most urgent. Software never sees the whole priority table at once. It writes a page number into a page register, and eight slot registers then expose the priorities of the eight consecutive lines in that page.

On every cycle the controller looks at all pending lines that have a nonzero priority and picks a winner. The winner is the highest level, and on a tie the lower line index. The winner is forwarded only when the global mask is clear and its level is strictly above the CPU's current interrupt priority level. A handler can therefore be pre-empted by more urgent sources (nesting). The request flag, the winning line index and its level are registered outputs. Vector fetch, stacking and CPU state are left to the CPU.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every line's priority reads back as 1, the page register reads 0, and `irq_o`, `irq_vec_o` and `irq_prio_o` are all 0.
- R2: A register write or read with `reg_addr_i[3]`=0 reaches the page register through `reg_wdata_i[3:0]`. One with `reg_addr_i[3]`=1 reaches the priority of line index {page, `reg_addr_i[2:0]`} through data bits [2:0]. So a line's index is its vector byte offset divided by 4, index bits [2:0] choose the slot and bits [6:3] the page. Written values read back unchanged, and neighbouring lines keep theirs.
- R3: A line whose priority is 0 is never forwarded, even while its request is held high.
- R4: Among pending lines with nonzero priority, the one with the highest level is forwarded with its index and level.
- R5: When several pending lines share the highest level, the lowest index wins.
- R6: A winner is forwarded only if its level is strictly greater than `ipl_i`.
- R7: While `mask_i` is 1, `irq_o` stays 0.
- R8: A priority write takes effect whether or not the line's request is currently asserted. Raising, lowering or zeroing the level of a pending line changes the forwarded result.
- R9: `irq_o`, `irq_vec_o` and `irq_prio_o` update exactly one clock edge after the inputs change. Both `irq_vec_o` and `irq_prio_o` are 0 whenever `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 128 | Pending request per line |
| ipl_i | input | 3 | Current CPU interrupt priority level |
| mask_i | input | 1 | Global mask of all maskable requests |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Bit 3 selects slot (1) or page (0); bits 2:0 pick the slot |
| reg_wdata_i | input | 4 | Write data |
| reg_rdata_o | output | 4 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | 7 | Winning line index |
| irq_prio_o | output | 3 | Winning priority level |

## Verification
The bench builds the controller with its default parameters: 128 lines, eight slots per page and 3-bit levels. This gives sixteen pages and a 4-bit register data path. With these values the top page and its last slot, line 127, are reachable through the window. Ties can span the full index range, from line 0 to line 127. The whole ladder of `ipl_i` from 0 to 7 can be set against each winning level.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned DEF_NUM_IRQ    = 128;
  localparam int unsigned DEF_SLOTS      = 8;
  localparam int unsigned DEF_PRIO_W     = 3;
  localparam int unsigned DEF_RESET_PRIO = 1;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/prio_window_regs.sv
module prio_window_regs
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ    = DEF_NUM_IRQ,
  parameter int unsigned SLOTS      = DEF_SLOTS,
  parameter int unsigned PRIO_W     = DEF_PRIO_W,
  parameter int unsigned RESET_PRIO = DEF_RESET_PRIO,
  localparam int unsigned SLOT_W    = width_of(SLOTS),
  localparam int unsigned PAGES     = NUM_IRQ / SLOTS,
  localparam int unsigned PAGE_W    = width_of(PAGES),
  localparam int unsigned ADDR_W    = SLOT_W + 1,
  localparam int unsigned DATA_W    = max_u(PAGE_W, PRIO_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PRIO_W-1:0] prio_o [NUM_IRQ]
);
  localparam int unsigned WIN_W = PAGE_W + SLOT_W;

  logic [PAGE_W-1:0] page_q;
  logic [PRIO_W-1:0] prio_q [NUM_IRQ];
  logic [WIN_W-1:0]  win_idx;
  logic              slot_sel;
  logic              idx_ok;

  // window position = page concatenated with slot number
  assign win_idx  = {page_q, addr_i[SLOT_W-1:0]};
  assign slot_sel = addr_i[ADDR_W-1];
  assign idx_ok   = 32'(win_idx) < NUM_IRQ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      for (int i = 0; i < NUM_IRQ; i++) prio_q[i] <= PRIO_W'(RESET_PRIO);
    end else if (we_i) begin
      if (!slot_sel) begin
        page_q <= wdata_i[PAGE_W-1:0];
      end else if (idx_ok) begin
        prio_q[win_idx] <= wdata_i[PRIO_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!slot_sel) begin
      rdata_o = DATA_W'(page_q);
    end else if (idx_ok) begin
      rdata_o = DATA_W'(prio_q[win_idx]);
    end
  end

  assign prio_o = prio_q;
endmodule

// File: rtl/prio_tree_arb.sv
module prio_tree_arb
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ = DEF_NUM_IRQ,
  parameter int unsigned PRIO_W  = DEF_PRIO_W,
  localparam int unsigned IDX_W  = width_of(NUM_IRQ),
  localparam int unsigned LEAVES = 1 << IDX_W,
  localparam int unsigned NODES  = 2 * LEAVES - 1
) (
  input  logic [NUM_IRQ-1:0] req_i,
  input  logic [PRIO_W-1:0]  prio_i [NUM_IRQ],
  output logic [PRIO_W-1:0]  win_prio_o,
  output logic [IDX_W-1:0]   win_idx_o
);
  logic [PRIO_W-1:0] node_p [NODES];
  logic [IDX_W-1:0]  node_i [NODES];

  // leaves in index order; pad beyond NUM_IRQ with level 0
  for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
    if (l < NUM_IRQ) begin : g_real
      assign node_p[LEAVES-1+l] = req_i[l] ? prio_i[l] : '0;
    end else begin : g_pad
      assign node_p[LEAVES-1+l] = '0;
    end
    assign node_i[LEAVES-1+l] = IDX_W'(l);
  end

  // right (higher index) child wins only on strictly higher level
  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    logic take_r;
    assign take_r    = node_p[2*n+2] > node_p[2*n+1];
    assign node_p[n] = take_r ? node_p[2*n+2] : node_p[2*n+1];
    assign node_i[n] = take_r ? node_i[2*n+2] : node_i[2*n+1];
  end

  assign win_prio_o = node_p[0];
  assign win_idx_o  = node_i[0];
endmodule

// File: rtl/irq_fwd_stage.sv
module irq_fwd_stage
  import prio_irq_pkg::*;
#(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned PRIO_W = DEF_PRIO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PRIO_W-1:0] win_prio_i,
  input  logic [IDX_W-1:0]  win_idx_i,
  input  logic [PRIO_W-1:0] ipl_i,
  input  logic              mask_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  irq_vec_o,
  output logic [PRIO_W-1:0] irq_prio_o
);
  logic fwd;

  // level 0 never exceeds ipl, so a disabled winner is dropped here too
  assign fwd = !mask_i && (win_prio_i > ipl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o      <= 1'b0;
      irq_vec_o  <= '0;
      irq_prio_o <= '0;
    end else begin
      irq_o      <= fwd;
      irq_vec_o  <= fwd ? win_idx_i  : '0;
      irq_prio_o <= fwd ? win_prio_i : '0;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ    = DEF_NUM_IRQ,
  parameter int unsigned SLOTS      = DEF_SLOTS,
  parameter int unsigned PRIO_W     = DEF_PRIO_W,
  parameter int unsigned RESET_PRIO = DEF_RESET_PRIO,
  localparam int unsigned IDX_W     = width_of(NUM_IRQ),
  localparam int unsigned SLOT_W    = width_of(SLOTS),
  localparam int unsigned PAGE_W    = width_of(NUM_IRQ / SLOTS),
  localparam int unsigned ADDR_W    = SLOT_W + 1,
  localparam int unsigned DATA_W    = max_u(PAGE_W, PRIO_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] req_i,
  input  logic [PRIO_W-1:0]  ipl_i,
  input  logic               mask_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o,
  output logic [IDX_W-1:0]   irq_vec_o,
  output logic [PRIO_W-1:0]  irq_prio_o
);
  logic [PRIO_W-1:0] prio_tab [NUM_IRQ];
  logic [PRIO_W-1:0] win_prio;
  logic [IDX_W-1:0]  win_idx;

  prio_window_regs #(
    .NUM_IRQ   (NUM_IRQ),
    .SLOTS     (SLOTS),
    .PRIO_W    (PRIO_W),
    .RESET_PRIO(RESET_PRIO)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .prio_o (prio_tab)
  );

  prio_tree_arb #(
    .NUM_IRQ(NUM_IRQ),
    .PRIO_W (PRIO_W)
  ) u_arb (
    .req_i     (req_i),
    .prio_i    (prio_tab),
    .win_prio_o(win_prio),
    .win_idx_o (win_idx)
  );

  irq_fwd_stage #(
    .IDX_W (IDX_W),
    .PRIO_W(PRIO_W)
  ) u_fwd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_prio_i(win_prio),
    .win_idx_i (win_idx),
    .ipl_i     (ipl_i),
    .mask_i    (mask_i),
    .irq_o     (irq_o),
    .irq_vec_o (irq_vec_o),
    .irq_prio_o(irq_prio_o)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned NUM_IRQ = 128,
  parameter int unsigned IDX_W   = 7,
  parameter int unsigned PRIO_W  = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_IRQ-1:0] req_i,
  input logic [PRIO_W-1:0]  ipl_i,
  input logic               mask_i,
  input logic               irq_o,
  input logic [IDX_W-1:0]   irq_vec_o,
  input logic [PRIO_W-1:0]  irq_prio_o
);
  logic [NUM_IRQ-1:0] req_q;
  logic [PRIO_W-1:0]  ipl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      ipl_q <= '0;
    end else begin
      req_q <= req_i;
      ipl_q <= ipl_i;
    end
  end

  AST_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |=> !irq_o); // R7
  AST_ABOVE_IPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_prio_o > ipl_q)); // R6
  AST_WINNER_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> req_q[irq_vec_o]); // R4
  AST_NONZERO_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_prio_o != '0)); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_vec_o == '0 && irq_prio_o == '0)); // R9
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_IRQ(NUM_IRQ),
  .IDX_W  (IDX_W),
  .PRIO_W (PRIO_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .ipl_i     (ipl_i),
  .mask_i    (mask_i),
  .irq_o     (irq_o),
  .irq_vec_o (irq_vec_o),
  .irq_prio_o(irq_prio_o)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  localparam int N = 128;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [2:0]   ipl_i = '0;
  logic         mask_i = 1'b0;
  logic         reg_we_i = 1'b0;
  logic [3:0]   reg_addr_i = '0;
  logic [3:0]   reg_wdata_i = '0;
  logic [3:0]   reg_rdata_o;
  logic         irq_o;
  logic [6:0]   irq_vec_o;
  logic [2:0]   irq_prio_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int model_prio [N];

  always #2 clk_i = ~clk_i;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .ipl_i      (ipl_i),
    .mask_i     (mask_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .irq_o      (irq_o),
    .irq_vec_o  (irq_vec_o),
    .irq_prio_o (irq_prio_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic reg_write(input int a, input int d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 4'(a); reg_wdata_i = 4'(d);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic set_prio(input int idx, input int p);
    reg_write(0, idx >> 3);
    reg_write(8 + (idx & 7), p);
    model_prio[idx] = p;
  endtask

  task automatic read_prio(input int idx, output int v);
    reg_write(0, idx >> 3);
    reg_addr_i = 4'(8 + (idx & 7));
    #1 v = int'(reg_rdata_o);
  endtask

  // expected forwarding from the requirements: highest level, lowest index on tie
  task automatic expect_irq(output int ev, output int ei, output int ep);
    int best = 0; int bi = 0;
    for (int i = 0; i < N; i++)
      if (req_i[i] && model_prio[i] != 0 && model_prio[i] > best) begin
        best = model_prio[i]; bi = i;
      end
    ev = (!mask_i && best > int'(ipl_i)) ? 1 : 0;
    ei = ev ? bi : 0;
    ep = ev ? best : 0;
  endtask

  task automatic check_irq(input string tag);
    int ev, ei, ep;
    expect_irq(ev, ei, ep);
    @(posedge clk_i); @(negedge clk_i);
    check(tag, "irq_o", int'(irq_o), ev);
    check(tag, "irq_vec_o", int'(irq_vec_o), ei);
    check(tag, "irq_prio_o", int'(irq_prio_o), ep);
  endtask

  task automatic t_reset();
    int bad = 0; int v;
    check("R1", "irq_o", int'(irq_o), 0);
    check("R1", "irq_vec_o", int'(irq_vec_o), 0);
    check("R1", "irq_prio_o", int'(irq_prio_o), 0);
    reg_addr_i = 4'd0; #1;
    check("R1", "page reset", int'(reg_rdata_o), 0);
    for (int i = 0; i < N; i++) begin
      read_prio(i, v);
      if (v != 1) bad++;
    end
    check("R1", "lines not at level 1", bad, 0);
  endtask

  task automatic t_window();
    int v;
    set_prio(116, 7);  // byte offset 0x1D0: page 14, slot 4
    read_prio(116, v); check("R2", "line 116 readback", v, 7);
    read_prio(115, v); check("R2", "line 115 untouched", v, 1);
    read_prio(117, v); check("R2", "line 117 untouched", v, 1);
    reg_addr_i = 4'd0; #1;
    check("R2", "page readback", int'(reg_rdata_o), 14);
    set_prio(127, 5);
    read_prio(127, v); check("R2", "line 127 readback", v, 5);
    req_i = '0; req_i[116] = 1'b1; req_i[127] = 1'b1;
    check_irq("R2");
    check("R2", "mapped vector", int'(irq_vec_o), 116);
    req_i = '0;
  endtask

  task automatic t_disable();
    set_prio(5, 0);
    req_i = '0; req_i[5] = 1'b1;
    check_irq("R3");
    check("R3", "zero level silent", int'(irq_o), 0);
    req_i[6] = 1'b1;
    check_irq("R3");
    check("R3", "other line wins", int'(irq_vec_o), 6);
    req_i = '0;
  endtask

  task automatic t_highest();
    set_prio(20, 3); set_prio(100, 6); set_prio(64, 2);
    req_i = '0; req_i[20] = 1'b1; req_i[100] = 1'b1; req_i[64] = 1'b1; req_i[3] = 1'b1;
    check_irq("R4");
    check("R4", "highest vector", int'(irq_vec_o), 100);
    req_i[100] = 1'b0;
    check_irq("R4");
    check("R4", "next highest", int'(irq_vec_o), 20);
    req_i = '0;
  endtask

  task automatic t_tie();
    set_prio(30, 4); set_prio(90, 4);
    req_i = '0; req_i[90] = 1'b1; req_i[30] = 1'b1;
    check_irq("R5");
    check("R5", "lower index on tie", int'(irq_vec_o), 30);
    req_i = '0; req_i[127] = 1'b0; req_i[0] = 1'b1; req_i[126] = 1'b1;
    check_irq("R5");
    check("R5", "line 0 over 126", int'(irq_vec_o), 0);
    req_i = '0;
  endtask

  task automatic t_ipl();
    req_i = '0; req_i[100] = 1'b1; req_i[20] = 1'b1;
    ipl_i = 3'd5; check_irq("R6");
    check("R6", "level 6 over ipl 5", int'(irq_o), 1);
    ipl_i = 3'd6; check_irq("R6");
    check("R6", "level 6 at ipl 6", int'(irq_o), 0);
    ipl_i = 3'd7; check_irq("R6");
    ipl_i = 3'd0; req_i = '0;
  endtask

  task automatic t_mask();
    req_i = '0; req_i[116] = 1'b1;
    mask_i = 1'b1; check_irq("R7");
    check("R7", "masked", int'(irq_o), 0);
    mask_i = 1'b0; check_irq("R7");
    check("R7", "unmasked", int'(irq_o), 1);
    req_i = '0;
  endtask

  task automatic t_live_write();
    req_i = '0; req_i[40] = 1'b1; req_i[41] = 1'b1;
    check_irq("R8");
    set_prio(41, 7); check_irq("R8");
    check("R8", "raised level wins", int'(irq_vec_o), 41);
    set_prio(41, 0); check_irq("R8");
    check("R8", "zeroed pending line", int'(irq_vec_o), 40);
    set_prio(40, 0); check_irq("R8");
    check("R8", "all zeroed", int'(irq_o), 0);
    req_i = '0;
  endtask

  task automatic t_timing();
    req_i = '0;
    @(posedge clk_i); @(negedge clk_i);
    req_i[116] = 1'b1;
    #1 check("R9", "no change before edge", int'(irq_o), 0);
    check("R9", "idle vector zero", int'(irq_vec_o), 0);
    @(posedge clk_i); #1;
    check("R9", "irq after one edge", int'(irq_o), 1);
    check("R9", "vector after one edge", int'(irq_vec_o), 116);
    @(negedge clk_i); req_i = '0;
    @(posedge clk_i); #1;
    check("R9", "drop after one edge", int'(irq_o), 0);
    check("R9", "idle level zero", int'(irq_prio_o), 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) model_prio[i] = 1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_window();
    t_disable();
    t_highest();
    t_tie();
    t_ipl();
    t_mask();
    t_live_write();
    t_timing();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule